// File: doc/BRIEF.md
# Banked General Register File

This block holds the sixteen 32-bit general registers of a small RISC core. The low eight names exist as two physical copies, bank 0 and bank 1. The high eight names are single registers that both banks share. A bank-select bit taken from the status register decides which copy of the low names the normal operand ports reach. The copy that is not selected stays reachable only through an alternate-bank port. That port serves the special control-register load and store operations.

The file has two combinational read ports and one synchronous write port. It also has a dedicated index output that always shows R0 of the active bank, for indexed address generation. A privilege input gates the banking. In non-privileged mode, bank 0 is forced and any alternate-bank access is refused. Every access completes in the cycle it is presented. No port applies back-pressure, so all pins are plain control and data pins with no valid/ready handshake.

Top module: `bankreg_file`

## Requirements
- R1: After reset, every register in both banks and every shared register reads zero, the index output is zero and the error flag is low.
- R2: In privileged mode with the effective bank equal to 1, normal reads and writes of names 0..7 reach bank 1, and bank 0 is not modified by them.
- R3: In privileged mode with the effective bank equal to 0, normal reads and writes of names 0..7 reach bank 0, and bank 1 is not modified by them.
- R4: Names 8..15 are shared: a value written under either bank reads back identically under both banks.
- R5: The alternate-bank port (3-bit address naming 0..7) reads and writes only the copy that is not selected, and the normal ports never observe that copy.
- R6: The index output always equals name 0 of the active bank.
- R7: When the privilege input is 0, the bank-select input is ignored and bank 0 is used from the next cycle on.
- R8: An alternate-bank read or write while the privilege input is 0 is refused: nothing is written, the alternate read data is zero, and the error flag is high for exactly the following cycle. The alternate read data is also zero whenever no alternate read is requested.
- R9: Writes take effect on the rising clock edge. A read of a name being written in the same cycle returns the old value.
- R10: A change of the bank-select input is applied at the next clock edge. Accesses in the cycle of the change still use the previous bank.
- R11: The two read ports are independent and may address any two names in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel_i | input | 1 | Bank-select bit from the status register |
| priv_i | input | 1 | 1 = privileged mode |
| rd0_addr_i | input | 4 | Read port 0 register name |
| rd0_data_o | output | 32 | Read port 0 data |
| rd1_addr_i | input | 4 | Read port 1 register name |
| rd1_data_o | output | 32 | Read port 1 data |
| wr_en_i | input | 1 | Normal write enable |
| wr_addr_i | input | 4 | Normal write register name |
| wr_data_i | input | 32 | Normal write data |
| alt_rd_en_i | input | 1 | Alternate-bank read request |
| alt_wr_en_i | input | 1 | Alternate-bank write request |
| alt_addr_i | input | 3 | Alternate-bank register name (0..7) |
| alt_wr_data_i | input | 32 | Alternate-bank write data |
| alt_rd_data_o | output | 32 | Alternate-bank read data |
| alt_err_o | output | 1 | Refused alternate access, one-cycle pulse |
| idx_o | output | 32 | R0 of the active bank |

## Verification
The bench uses the package defaults: 32-bit words, sixteen names and eight banked names. With these values, every banked name, every shared name and both banks can be covered in a short directed run. A reference model holds both banks, the shared registers, the pending bank and the error flag. It predicts all read outputs in every cycle, so the one-cycle bank-switch delay is checked in every cycle. So are the same-cycle read-before-write rule and the isolation of the alternate port.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  parameter int unsigned DATA_W     = 32;
  parameter int unsigned NUM_NAMES  = 16;
  parameter int unsigned NUM_BANKED = 8;

  localparam int unsigned NUM_SHARED = NUM_NAMES - NUM_BANKED;
  localparam int unsigned ADDR_W     = $clog2(NUM_NAMES);
  localparam int unsigned BADDR_W    = $clog2(NUM_BANKED);
  localparam int unsigned SADDR_W    = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [ADDR_W-1:0]  raddr_t;
  typedef logic [BADDR_W-1:0] baddr_t;
  typedef logic [SADDR_W-1:0] saddr_t;

  typedef word_t [NUM_BANKED-1:0] bank_arr_t;
  typedef word_t [NUM_SHARED-1:0] shared_arr_t;
endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bank_sel_i,
  input  logic priv_i,
  input  logic alt_rd_en_i,
  input  logic alt_wr_en_i,
  output logic bank_o,
  output logic alt_rd_ok_o,
  output logic alt_wr_ok_o,
  output logic alt_err_o
);
  logic bank_q;
  logic err_q;
  logic alt_req;

  assign alt_req = alt_rd_en_i | alt_wr_en_i;

  // Effective bank is registered: a new select applies from the next cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      bank_q <= bank_sel_i & priv_i;
      err_q  <= alt_req & ~priv_i;
    end
  end

  assign bank_o      = bank_q;
  assign alt_rd_ok_o = alt_rd_en_i & priv_i;
  assign alt_wr_ok_o = alt_wr_en_i & priv_i;
  assign alt_err_o   = err_q;

  AST_USER_FORCES_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_i |=> !bank_o); // R7
  AST_BANK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i |=> (bank_o == $past(bank_sel_i))); // R10
  AST_ERR_ON_USER_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_req && !priv_i) |=> alt_err_o); // R8
  AST_NO_ERR_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i |=> !alt_err_o); // R8
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bank_i,
  input  logic        wr_en_i,
  input  raddr_t      wr_addr_i,
  input  word_t       wr_data_i,
  input  logic        alt_we_i,
  input  baddr_t      alt_addr_i,
  input  word_t       alt_data_i,
  output bank_arr_t   bank0_o,
  output bank_arr_t   bank1_o,
  output shared_arr_t shared_o
);
  bank_arr_t   bank0_q;
  bank_arr_t   bank1_q;
  shared_arr_t shared_q;
  saddr_t      sh_idx;

  assign sh_idx = saddr_t'(wr_addr_i - raddr_t'(NUM_BANKED));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKED; gi++) begin : g_banked
      logic n_hit;
      logic a_hit;
      assign n_hit = wr_en_i && (wr_addr_i == raddr_t'(gi));
      assign a_hit = alt_we_i && (alt_addr_i == baddr_t'(gi));

      // Normal path reaches the active copy, alternate path the other one.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bank0_q[gi] <= '0;
          bank1_q[gi] <= '0;
        end else begin
          if (n_hit && !bank_i)      bank0_q[gi] <= wr_data_i;
          else if (a_hit && bank_i)  bank0_q[gi] <= alt_data_i;
          if (n_hit && bank_i)       bank1_q[gi] <= wr_data_i;
          else if (a_hit && !bank_i) bank1_q[gi] <= alt_data_i;
        end
      end
    end

    for (gi = 0; gi < NUM_SHARED; gi++) begin : g_shared
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          shared_q[gi] <= '0;
        else if (wr_en_i && (wr_addr_i == raddr_t'(gi + NUM_BANKED)))
          shared_q[gi] <= wr_data_i;
      end
    end
  endgenerate

  assign bank0_o  = bank0_q;
  assign bank1_o  = bank1_q;
  assign shared_o = shared_q;

  AST_BANK1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_i && !alt_we_i) |=> $stable(bank1_q)); // R3
  AST_BANK0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_i && !alt_we_i) |=> $stable(bank0_q)); // R2
  AST_SHARED_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_addr_i >= raddr_t'(NUM_BANKED)))
      |=> (shared_q[$past(sh_idx)] == $past(wr_data_i))); // R4
endmodule

// File: rtl/bankreg_rdport.sv
module bankreg_rdport
  import bankreg_pkg::*;
(
  input  logic        bank_i,
  input  raddr_t      addr_i,
  input  bank_arr_t   bank0_i,
  input  bank_arr_t   bank1_i,
  input  shared_arr_t shared_i,
  output word_t       data_o
);
  baddr_t b_idx;
  saddr_t s_idx;

  assign b_idx = baddr_t'(addr_i);
  assign s_idx = saddr_t'(addr_i - raddr_t'(NUM_BANKED));

  always_comb begin
    if (addr_i < raddr_t'(NUM_BANKED))
      data_o = bank_i ? bank1_i[b_idx] : bank0_i[b_idx];
    else
      data_o = shared_i[s_idx];
  end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bank_sel_i,
  input  logic                  priv_i,
  input  logic [ADDR_W-1:0]     rd0_addr_i,
  output logic [DATA_W-1:0]     rd0_data_o,
  input  logic [ADDR_W-1:0]     rd1_addr_i,
  output logic [DATA_W-1:0]     rd1_data_o,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  alt_rd_en_i,
  input  logic                  alt_wr_en_i,
  input  logic [BADDR_W-1:0]    alt_addr_i,
  input  logic [DATA_W-1:0]     alt_wr_data_i,
  output logic [DATA_W-1:0]     alt_rd_data_o,
  output logic                  alt_err_o,
  output logic [DATA_W-1:0]     idx_o
);
  localparam int unsigned NUM_RD = 2;

  logic        bank;
  logic        alt_rd_ok;
  logic        alt_wr_ok;
  bank_arr_t   bank0;
  bank_arr_t   bank1;
  shared_arr_t shared;
  raddr_t      rd_addr [NUM_RD];
  word_t       rd_data [NUM_RD];
  word_t       alt_raw;

  bankreg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_sel_i  (bank_sel_i),
    .priv_i      (priv_i),
    .alt_rd_en_i (alt_rd_en_i),
    .alt_wr_en_i (alt_wr_en_i),
    .bank_o      (bank),
    .alt_rd_ok_o (alt_rd_ok),
    .alt_wr_ok_o (alt_wr_ok),
    .alt_err_o   (alt_err_o)
  );

  bankreg_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_i     (bank),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .alt_we_i   (alt_wr_ok),
    .alt_addr_i (alt_addr_i),
    .alt_data_i (alt_wr_data_i),
    .bank0_o    (bank0),
    .bank1_o    (bank1),
    .shared_o   (shared)
  );

  assign rd_addr[0] = rd0_addr_i;
  assign rd_addr[1] = rd1_addr_i;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_RD; gp++) begin : g_rd
      bankreg_rdport u_rd (
        .bank_i   (bank),
        .addr_i   (rd_addr[gp]),
        .bank0_i  (bank0),
        .bank1_i  (bank1),
        .shared_i (shared),
        .data_o   (rd_data[gp])
      );
    end
  endgenerate

  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];

  // Index output: name 0 of the active copy.
  bankreg_rdport u_idx (
    .bank_i   (bank),
    .addr_i   ('0),
    .bank0_i  (bank0),
    .bank1_i  (bank1),
    .shared_i (shared),
    .data_o   (idx_o)
  );

  // Alternate read: same mux with the bank inverted.
  bankreg_rdport u_alt (
    .bank_i   (~bank),
    .addr_i   (raddr_t'(alt_addr_i)),
    .bank0_i  (bank0),
    .bank1_i  (bank1),
    .shared_i (shared),
    .data_o   (alt_raw)
  );

  assign alt_rd_data_o = alt_rd_ok ? alt_raw : '0;

  AST_IDX_IS_R0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr_i == '0) |-> (rd0_data_o == idx_o)); // R6
  AST_ALT_SILENT_USER: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_i |-> (alt_rd_data_o == '0)); // R8
endmodule

// File: tb/bankreg_file_tb_top.sv
module bankreg_file_tb_top;
  import bankreg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_sel_i = 1'b0, priv_i = 1'b0;
  raddr_t rd0_addr_i = '0, rd1_addr_i = '0, wr_addr_i = '0;
  word_t  rd0_data_o, rd1_data_o, wr_data_i = '0;
  logic wr_en_i = 1'b0, alt_rd_en_i = 1'b0, alt_wr_en_i = 1'b0;
  baddr_t alt_addr_i = '0;
  word_t alt_wr_data_i = '0, alt_rd_data_o, idx_o;
  logic alt_err_o;

  always #5 clk = ~clk;

  bankreg_file dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel_i), .priv_i(priv_i),
    .rd0_addr_i(rd0_addr_i), .rd0_data_o(rd0_data_o),
    .rd1_addr_i(rd1_addr_i), .rd1_data_o(rd1_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .alt_rd_en_i(alt_rd_en_i), .alt_wr_en_i(alt_wr_en_i),
    .alt_addr_i(alt_addr_i), .alt_wr_data_i(alt_wr_data_i),
    .alt_rd_data_o(alt_rd_data_o), .alt_err_o(alt_err_o), .idx_o(idx_o)
  );

  // Reference model
  word_t m_b0 [NUM_BANKED];
  word_t m_b1 [NUM_BANKED];
  word_t m_sh [NUM_SHARED];
  logic  m_bank = 1'b0;
  logic  m_err  = 1'b0;

  typedef struct {
    int    sel;
    word_t exp;
    string tag;
  } item_t;
  item_t sb_q [$];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic word_t m_read(raddr_t a, logic bk);
    if (a < raddr_t'(NUM_BANKED)) return bk ? m_b1[int'(a)] : m_b0[int'(a)];
    return m_sh[int'(a) - NUM_BANKED];
  endfunction

  function automatic void push(int sel, word_t exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endfunction

  // Push expectations for the current inputs, then step one clock.
  task automatic cycle(string tag);
    word_t alt_exp;
    alt_exp = (alt_rd_en_i && priv_i) ? m_read(raddr_t'(alt_addr_i), ~m_bank) : '0;
    push(0, m_read(rd0_addr_i, m_bank), tag);
    push(1, m_read(rd1_addr_i, m_bank), tag);
    push(2, m_read('0, m_bank), tag);
    push(3, alt_exp, tag);
    push(4, word_t'(m_err), tag);
    @(posedge clk);
    if (rst_n) begin
      if (wr_en_i) begin
        if (wr_addr_i < raddr_t'(NUM_BANKED)) begin
          if (m_bank) m_b1[int'(wr_addr_i)] = wr_data_i;
          else        m_b0[int'(wr_addr_i)] = wr_data_i;
        end else m_sh[int'(wr_addr_i) - NUM_BANKED] = wr_data_i;
      end
      if (alt_wr_en_i && priv_i) begin
        if (m_bank) m_b0[int'(alt_addr_i)] = alt_wr_data_i;
        else        m_b1[int'(alt_addr_i)] = alt_wr_data_i;
      end
      m_err  = (alt_rd_en_i || alt_wr_en_i) && !priv_i;
      m_bank = bank_sel_i && priv_i;
    end
    #1;
  endtask

  task automatic drv(logic bs, logic pv, logic we, int wa, word_t wd,
                     int r0, int r1, logic are, logic awe, int aa, word_t ad,
                     string tag);
    bank_sel_i = bs; priv_i = pv; wr_en_i = we; wr_addr_i = raddr_t'(wa);
    wr_data_i = wd; rd0_addr_i = raddr_t'(r0); rd1_addr_i = raddr_t'(r1);
    alt_rd_en_i = are; alt_wr_en_i = awe; alt_addr_i = baddr_t'(aa);
    alt_wr_data_i = ad;
    cycle(tag);
  endtask

  // Monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      word_t got;
      it = sb_q.pop_front();
      case (it.sel)
        0: got = rd0_data_o;
        1: got = rd1_data_o;
        2: got = idx_o;
        3: got = alt_rd_data_o;
        default: got = word_t'(alt_err_o);
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d got=%h exp=%h", it.tag, it.sel, got, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_BANKED; i++) begin m_b0[i] = '0; m_b1[i] = '0; end
    for (int i = 0; i < NUM_SHARED; i++) m_sh[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, reads of low and high names
    drv(0,1,0,0,0, 3,12, 1,0,5,0, "R1");
    drv(0,1,0,0,0, 0,15, 0,0,0,0, "R1");
    // R3: fill bank 0 under select 0
    for (int i = 0; i < NUM_BANKED; i++)
      drv(0,1,1,i,32'h0B00_0000 + i, i,7, 0,0,0,0, "R3");
    // R9: read of the name being written returns old value
    drv(0,1,1,2,32'hDEAD_0002, 2,2, 0,0,0,0, "R9");
    drv(0,1,0,0,0, 2,0, 0,0,0,0, "R9");
    // R10: select rises; this cycle's write still lands in bank 0
    drv(1,1,1,4,32'h0B00_0044, 4,1, 0,0,0,0, "R10");
    // R2: bank 1 now active, reads zero, then fill
    drv(1,1,0,0,0, 4,0, 0,0,0,0, "R2");
    for (int i = 0; i < NUM_BANKED; i++)
      drv(1,1,1,i,32'hB1B1_0000 + i, i,0, 0,0,0,0, "R2");
    // R4: shared names written under bank 1
    for (int i = NUM_BANKED; i < NUM_NAMES; i++)
      drv(1,1,1,i,32'h5A00_0000 + i, i,i, 0,0,0,0, "R4");
    // R5: alternate reads see bank 0 while bank 1 active
    for (int i = 0; i < NUM_BANKED; i++)
      drv(1,1,0,0,0, i,9, 1,0,i,0, "R5");
    // R5: alternate write to bank 0; normal port still sees bank 1
    drv(1,1,0,0,0, 5,0, 0,1,5,32'hA17A_0005, "R5");
    drv(1,1,0,0,0, 5,3, 1,0,5,0, "R5");
    // R6: index follows active R0 across switch
    drv(0,1,0,0,0, 0,0, 0,1,0,32'h1D1D_0000, "R6");
    drv(0,1,0,0,0, 0,8, 1,0,0,0, "R6");
    // R4: shared visible under bank 0
    for (int i = NUM_BANKED; i < NUM_NAMES; i++)
      drv(0,1,0,0,0, i,NUM_NAMES-1-(i-NUM_BANKED), 0,0,0,0, "R4");
    // R11: independent ports
    drv(0,1,0,0,0, 1,14, 1,0,3,0, "R11");
    // R7: user mode ignores select 1
    drv(1,0,0,0,0, 6,0, 0,0,0,0, "R7");
    drv(1,0,1,6,32'h0EE0_0006, 6,0, 0,0,0,0, "R7");
    drv(1,0,0,0,0, 6,7, 0,0,0,0, "R7");
    // R8: refused alternate write and read, error pulse
    drv(1,0,0,0,0, 3,0, 1,1,3,32'hBAD0_BAD0, "R8");
    drv(1,0,0,0,0, 3,0, 0,0,0,0, "R8");
    drv(1,0,0,0,0, 3,0, 0,0,0,0, "R8");
    // R8: back to privileged bank 0, bank 1 name 3 unchanged
    drv(0,1,0,0,0, 3,0, 1,0,3,0, "R8");
    drv(0,1,0,0,0, 3,0, 1,0,3,0, "R8");
    done = 1'b1;
    @(negedge clk); #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule